// File: doc/BRIEF.md
# Graphics LCD Bus Bridge

This block sits between a simple processor register bus and a text/graphics LCD controller with an 8-bit parallel interface (chip enable, command/data select, read strobe, write strobe). Four low register addresses each start one kind of controller cycle: command write, data write, status read and data read. The processor raises a request with address, direction and write data, and holds it until the bridge returns a one-cycle ready pulse. The bridge stretches every controller cycle into setup, strobe and hold phases. Each phase lasts a set number of clock cycles given by a parameter. Throughout, the processor is held in a wait state.

A small helper register set converts screen positions into display-RAM addresses, so software does not have to multiply. Software loads a text-area base, a characters-per-line count, a graphics-area base, a bytes-per-line count and a row/column cursor. It then reads back the address of the matching text cell, and the address of the graphics byte that holds the addressed pixel (six pixels per byte). The controller data bus is exposed as separate in, out and output-enable signals, so the pad tri-state buffer lives at the chip edge.

Top module: `lcd_bus_bridge`

## Requirements
- R1: After reset, lcd_ce_n, lcd_wr_n and lcd_rd_n are 1, lcd_doe, cpu_ready and cpu_rdata are 0.
- R2: The controller cycle type is chosen by cpu_addr: 0 = command write (lcd_cd=1), 1 = data write (lcd_cd=0), 2 = status read (lcd_cd=1), 3 = data read (lcd_cd=0). Each access gives exactly one chip-enable window. On writes, lcd_dout carries cpu_wdata.
- R3: Within a chip-enable window, lcd_ce_n and lcd_cd are held for T_SU cycles before the strobe. The strobe (lcd_wr_n for writes, lcd_rd_n for reads) is low for T_PW cycles. Chip enable stays low for T_H cycles after the strobe. The two strobes are never low together, and lcd_cd does not change inside the window.
- R4: For a controller access, cpu_ready stays 0 until hold ends. It then pulses high for one cycle, T_SU+T_PW+T_H clock edges after the edge that accepts the request. When cpu_ready is high, the controller bus is released.
- R5: On a read, cpu_rdata holds the value on lcd_din at the clock edge that ends the last strobe-low cycle.
- R6: lcd_doe is 1 for the whole chip-enable window of a write, and lcd_dout is stable throughout. On reads lcd_doe stays 0.
- R7: A write to address 2 or 3, or a read from address 0 or 1, completes with ready on the first edge after acceptance. It makes no chip-enable window and returns cpu_rdata 0.
- R8: The text address read at 12 (low byte) and 13 (high byte) equals text_base + row × text_cols + col, modulo 2^16. The bases are written at 4/5 (low/high), text_cols at 6, row at 10 and col at 11.
- R9: A value above 40 written to text_cols (address 6) or to bytes-per-line (address 9) is stored as 40. Values up to 40 are stored unchanged, and both read back at their own addresses.
- R10: The graphics address read at 14/15 equals gfx_base + row × bytes_per_line + col/6 (integer division), modulo 2^16, with gfx_base written at 7/8.
- R11: Helper register accesses (addresses 4–15) complete in one cycle with no controller activity. Reads of 4–11 return the stored value, and writes to 12–15 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 4 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid while cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| lcd_ce_n | output | 1 | Controller chip enable, active low |
| lcd_cd | output | 1 | 1 = command/status, 0 = data |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, active low |
| lcd_dout | output | 8 | Data toward the controller |
| lcd_doe | output | 1 | Output enable for the pad tri-state |
| lcd_din | input | 8 | Data from the controller |

## Verification
Every cycle, the assertions check the bus-level rules. The strobes are mutually exclusive and sit inside chip enable, with at least one cycle of setup before and hold after. lcd_cd and the driven data stay stable across the window, ready is a single-cycle pulse on a released bus, and output enable is never on during a read strobe. The exact phase lengths, the ready latency and the cycle on which read data is captured are left to the bench. So are the mapping of addresses to cycle types, the rejection of mismatched directions and the address arithmetic with clamping. The bench measures these against a controller model and against functions computed from the requirements.

// File: rtl/lcd_bridge_pkg.sv
package lcd_bridge_pkg;
  localparam int REG_AW = 4;
  localparam int RAM_AW = 16;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_DONE
  } phase_t;

  // controller cycle addresses
  localparam logic [REG_AW-1:0] A_CMD_WR  = 4'd0;
  localparam logic [REG_AW-1:0] A_DAT_WR  = 4'd1;
  localparam logic [REG_AW-1:0] A_STAT_RD = 4'd2;
  localparam logic [REG_AW-1:0] A_DAT_RD  = 4'd3;
  // helper registers
  localparam logic [REG_AW-1:0] A_TXT_LO  = 4'd4;
  localparam logic [REG_AW-1:0] A_TXT_HI  = 4'd5;
  localparam logic [REG_AW-1:0] A_TXT_COL = 4'd6;
  localparam logic [REG_AW-1:0] A_GFX_LO  = 4'd7;
  localparam logic [REG_AW-1:0] A_GFX_HI  = 4'd8;
  localparam logic [REG_AW-1:0] A_GFX_BPL = 4'd9;
  localparam logic [REG_AW-1:0] A_ROW     = 4'd10;
  localparam logic [REG_AW-1:0] A_COL     = 4'd11;
  localparam logic [REG_AW-1:0] A_TADR_LO = 4'd12;
  localparam logic [REG_AW-1:0] A_TADR_HI = 4'd13;
  localparam logic [REG_AW-1:0] A_GADR_LO = 4'd14;
  localparam logic [REG_AW-1:0] A_GADR_HI = 4'd15;
endpackage

// File: rtl/lcd_bus_seq.sv
module lcd_bus_seq
  import lcd_bridge_pkg::*;
#(
  parameter int T_SU = 2,
  parameter int T_PW = 2,
  parameter int T_H  = 2,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_lcd,
  input  logic          go_local,
  input  logic          op_write,
  input  logic          op_cmd,
  input  logic [DW-1:0] wdata,
  output logic          idle,
  output logic          cap_now,
  output logic          ready,
  output logic          lcd_ce_n,
  output logic          lcd_cd,
  output logic          lcd_wr_n,
  output logic          lcd_rd_n,
  output logic          lcd_doe,
  output logic [DW-1:0] lcd_dout
);
  localparam int T_A   = (T_SU > T_PW) ? T_SU : T_PW;
  localparam int T_MAX = (T_A > T_H) ? T_A : T_H;
  localparam int CW    = $clog2(T_MAX + 1);

  phase_t        ph, ph_nxt;
  logic [CW-1:0] cnt;
  logic          wr_l;
  logic          in_bus;
  logic          wr_eff;

  always_comb begin
    ph_nxt = ph;
    unique case (ph)
      PH_IDLE: begin
        if (go_lcd)        ph_nxt = PH_SETUP;
        else if (go_local) ph_nxt = PH_DONE;
      end
      PH_SETUP:  if (cnt == CW'(T_SU - 1)) ph_nxt = PH_STROBE;
      PH_STROBE: if (cnt == CW'(T_PW - 1)) ph_nxt = PH_HOLD;
      PH_HOLD:   if (cnt == CW'(T_H - 1))  ph_nxt = PH_DONE;
      PH_DONE:   ph_nxt = PH_IDLE;
      default:   ph_nxt = PH_IDLE;
    endcase
  end

  assign in_bus  = (ph_nxt == PH_SETUP) || (ph_nxt == PH_STROBE) || (ph_nxt == PH_HOLD);
  assign wr_eff  = (ph == PH_IDLE) ? op_write : wr_l;
  assign idle    = (ph == PH_IDLE);
  assign cap_now = (ph == PH_STROBE) && (cnt == CW'(T_PW - 1)) && !wr_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      cnt      <= '0;
      wr_l     <= 1'b0;
      lcd_ce_n <= 1'b1;
      lcd_cd   <= 1'b1;
      lcd_wr_n <= 1'b1;
      lcd_rd_n <= 1'b1;
      lcd_doe  <= 1'b0;
      lcd_dout <= '0;
      ready    <= 1'b0;
    end else begin
      ph  <= ph_nxt;
      cnt <= (ph_nxt != ph || ph == PH_IDLE) ? '0 : cnt + CW'(1);
      if (ph == PH_IDLE && go_lcd) begin
        wr_l   <= op_write;
        lcd_cd <= op_cmd;
        if (op_write) lcd_dout <= wdata;
      end
      lcd_ce_n <= !in_bus;
      lcd_wr_n <= !((ph_nxt == PH_STROBE) && wr_eff);
      lcd_rd_n <= !((ph_nxt == PH_STROBE) && !wr_eff);
      lcd_doe  <= in_bus && wr_eff;
      ready    <= (ph_nxt == PH_DONE);
    end
  end
endmodule

// File: rtl/lcd_addr_calc.sv
module lcd_addr_calc
  import lcd_bridge_pkg::*;
#(
  parameter int MAX_COLS     = 40,
  parameter int PIX_PER_BYTE = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_sel,
  input  logic [7:0]        wdata,
  input  logic [REG_AW-1:0] rd_sel,
  output logic [7:0]        rd_val
);
  localparam int COLW = $clog2(MAX_COLS + 1);

  logic [RAM_AW-1:0] txt_home, gfx_home, txt_addr, gfx_addr;
  logic [COLW-1:0]   txt_cols, gfx_bpl;
  logic [7:0]        cur_row, cur_col, gfx_byte_col;

  function automatic logic [COLW-1:0] clamp_cols(input logic [7:0] v);
    return (v > 8'(MAX_COLS)) ? COLW'(MAX_COLS) : v[COLW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      txt_home <= '0;
      gfx_home <= '0;
      txt_cols <= COLW'(MAX_COLS);
      gfx_bpl  <= COLW'(MAX_COLS);
      cur_row  <= '0;
      cur_col  <= '0;
    end else if (wr_en) begin
      unique case (wr_sel)
        A_TXT_LO:  txt_home[7:0]        <= wdata;
        A_TXT_HI:  txt_home[RAM_AW-1:8] <= wdata;
        A_TXT_COL: txt_cols             <= clamp_cols(wdata);
        A_GFX_LO:  gfx_home[7:0]        <= wdata;
        A_GFX_HI:  gfx_home[RAM_AW-1:8] <= wdata;
        A_GFX_BPL: gfx_bpl              <= clamp_cols(wdata);
        A_ROW:     cur_row              <= wdata;
        A_COL:     cur_col              <= wdata;
        default: ;
      endcase
    end
  end

  assign gfx_byte_col = cur_col / 8'(PIX_PER_BYTE);
  assign txt_addr = txt_home + RAM_AW'(cur_row) * RAM_AW'(txt_cols) + RAM_AW'(cur_col);
  assign gfx_addr = gfx_home + RAM_AW'(cur_row) * RAM_AW'(gfx_bpl) + RAM_AW'(gfx_byte_col);

  always_comb begin
    rd_val = '0;
    unique case (rd_sel)
      A_TXT_LO:  rd_val = txt_home[7:0];
      A_TXT_HI:  rd_val = txt_home[RAM_AW-1:8];
      A_TXT_COL: rd_val = 8'(txt_cols);
      A_GFX_LO:  rd_val = gfx_home[7:0];
      A_GFX_HI:  rd_val = gfx_home[RAM_AW-1:8];
      A_GFX_BPL: rd_val = 8'(gfx_bpl);
      A_ROW:     rd_val = cur_row;
      A_COL:     rd_val = cur_col;
      A_TADR_LO: rd_val = txt_addr[7:0];
      A_TADR_HI: rd_val = txt_addr[RAM_AW-1:8];
      A_GADR_LO: rd_val = gfx_addr[7:0];
      A_GADR_HI: rd_val = gfx_addr[RAM_AW-1:8];
      default:   rd_val = '0;
    endcase
  end
endmodule

// File: rtl/lcd_bus_bridge.sv
module lcd_bus_bridge
  import lcd_bridge_pkg::*;
#(
  parameter int T_SU         = 2,
  parameter int T_PW         = 2,
  parameter int T_H          = 2,
  parameter int MAX_COLS     = 40,
  parameter int PIX_PER_BYTE = 6,
  parameter int DW           = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [REG_AW-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_rdata,
  output logic              cpu_ready,
  output logic              lcd_ce_n,
  output logic              lcd_cd,
  output logic              lcd_wr_n,
  output logic              lcd_rd_n,
  output logic [DW-1:0]     lcd_dout,
  output logic              lcd_doe,
  input  logic [DW-1:0]     lcd_din
);
  logic       seq_idle, cap_now;
  logic       lcd_space, wr_addr, dir_ok, go_lcd, go_local, op_cmd, hlp_wr;
  logic [7:0] hlp_rd;

  assign lcd_space = (cpu_addr[REG_AW-1:2] == '0);
  assign wr_addr   = (cpu_addr == A_CMD_WR) || (cpu_addr == A_DAT_WR);
  assign dir_ok    = wr_addr ? cpu_we : !cpu_we;
  assign go_lcd    = cpu_req && seq_idle && lcd_space && dir_ok;
  assign go_local  = cpu_req && seq_idle && !(lcd_space && dir_ok);
  assign op_cmd    = (cpu_addr == A_CMD_WR) || (cpu_addr == A_STAT_RD);
  assign hlp_wr    = go_local && cpu_we && !lcd_space;

  lcd_bus_seq #(
    .T_SU(T_SU), .T_PW(T_PW), .T_H(T_H), .DW(DW)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .go_lcd   (go_lcd),
    .go_local (go_local),
    .op_write (cpu_we),
    .op_cmd   (op_cmd),
    .wdata    (cpu_wdata),
    .idle     (seq_idle),
    .cap_now  (cap_now),
    .ready    (cpu_ready),
    .lcd_ce_n (lcd_ce_n),
    .lcd_cd   (lcd_cd),
    .lcd_wr_n (lcd_wr_n),
    .lcd_rd_n (lcd_rd_n),
    .lcd_doe  (lcd_doe),
    .lcd_dout (lcd_dout)
  );

  lcd_addr_calc #(
    .MAX_COLS(MAX_COLS), .PIX_PER_BYTE(PIX_PER_BYTE)
  ) u_calc (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (hlp_wr),
    .wr_sel (cpu_addr),
    .wdata  (cpu_wdata[7:0]),
    .rd_sel (cpu_addr),
    .rd_val (hlp_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
    end else if (cap_now) begin
      cpu_rdata <= lcd_din;
    end else if (go_local) begin
      cpu_rdata <= (lcd_space || cpu_we) ? '0 : DW'(hlp_rd);
    end else if (go_lcd) begin
      cpu_rdata <= '0;
    end
  end
endmodule

// File: rtl/lcd_bus_bridge_chk.sv
module lcd_bus_bridge_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_ready,
  input logic          lcd_ce_n,
  input logic          lcd_cd,
  input logic          lcd_wr_n,
  input logic          lcd_rd_n,
  input logic          lcd_doe,
  input logic [DW-1:0] lcd_dout
);
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(!lcd_wr_n && !lcd_rd_n));

  p_strobe_in_ce_r3: assert property (@(posedge clk) disable iff (rst)
    (!lcd_wr_n || !lcd_rd_n) |-> !lcd_ce_n);

  p_setup_wr_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_wr_n) |-> $past(!lcd_ce_n));

  p_setup_rd_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_rd_n) |-> $past(!lcd_ce_n));

  p_hold_wr_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(lcd_wr_n) |-> !lcd_ce_n);

  p_hold_rd_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(lcd_rd_n) |-> !lcd_ce_n);

  p_cd_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (!lcd_ce_n && $past(!lcd_ce_n)) |-> $stable(lcd_cd));

  p_ready_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  p_ready_released_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> (lcd_ce_n && lcd_wr_n && lcd_rd_n && !lcd_doe));

  p_doe_not_read_r6: assert property (@(posedge clk) disable iff (rst)
    lcd_doe |-> (!lcd_ce_n && lcd_rd_n));

  p_dout_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (lcd_doe && $past(lcd_doe)) |-> $stable(lcd_dout));
endmodule

bind lcd_bus_bridge lcd_bus_bridge_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_ready (cpu_ready),
  .lcd_ce_n  (lcd_ce_n),
  .lcd_cd    (lcd_cd),
  .lcd_wr_n  (lcd_wr_n),
  .lcd_rd_n  (lcd_rd_n),
  .lcd_doe   (lcd_doe),
  .lcd_dout  (lcd_dout)
);

// File: tb/lcd_bus_bridge_bench.sv
`timescale 1ns/1ps
module lcd_bus_bridge_bench;
  localparam int T_SU = 2;
  localparam int T_PW = 3;
  localparam int T_H  = 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_req = 1'b0, cpu_we = 1'b0;
  logic [3:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic       cpu_ready;
  logic       lcd_ce_n, lcd_cd, lcd_wr_n, lcd_rd_n, lcd_doe;
  logic [7:0] lcd_dout;
  logic [7:0] lcd_din = 8'h5A;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lcd_bus_bridge #(.T_SU(T_SU), .T_PW(T_PW), .T_H(T_H)) u_lcd_bus_bridge (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .lcd_ce_n(lcd_ce_n), .lcd_cd(lcd_cd), .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n),
    .lcd_dout(lcd_dout), .lcd_doe(lcd_doe), .lcd_din(lcd_din)
  );

  // controller model and bus monitor
  logic [7:0] stat_val = 8'h11, data_val = 8'h22;
  int  txn_cnt = 0;
  bit  in_win = 0;
  int  su, pw, hd;
  bit  strobed, wr_seen, rd_seen, doe_all, doe_any, dout_ok, cd_ok;
  logic       cd0;
  logic [7:0] dout0;
  int  l_su, l_pw, l_hd;
  bit  l_wr, l_rd, l_doe_all, l_doe_any, l_dout_ok, l_cd_ok;
  logic       l_cd;
  logic [7:0] l_dout;

  always @(negedge clk) begin
    lcd_din <= (!lcd_rd_n) ? (lcd_cd ? stat_val : data_val) : 8'h5A;
    if (rst) begin
      in_win = 0;
    end else if (!lcd_ce_n) begin
      if (!in_win) begin
        su = 0; pw = 0; hd = 0; strobed = 0; wr_seen = 0; rd_seen = 0;
        doe_all = 1; doe_any = 0; dout_ok = 1; cd_ok = 1;
        cd0 = lcd_cd; dout0 = lcd_dout;
      end
      in_win = 1;
      if (!lcd_wr_n || !lcd_rd_n) begin
        pw++; strobed = 1;
        wr_seen |= !lcd_wr_n; rd_seen |= !lcd_rd_n;
      end else if (!strobed) su++;
      else hd++;
      doe_all &= lcd_doe; doe_any |= lcd_doe;
      if (lcd_dout != dout0) dout_ok = 0;
      if (lcd_cd != cd0) cd_ok = 0;
    end else if (in_win) begin
      in_win = 0; txn_cnt++;
      l_su = su; l_pw = pw; l_hd = hd; l_wr = wr_seen; l_rd = rd_seen;
      l_doe_all = doe_all; l_doe_any = doe_any; l_dout_ok = dout_ok;
      l_cd_ok = cd_ok; l_cd = cd0; l_dout = dout0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cpu_access(input logic [3:0] a, input logic w, input logic [7:0] d,
                            output logic [7:0] rd, output int n);
    cpu_req = 1; cpu_addr = a; cpu_we = w; cpu_wdata = d; n = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
    end while (!cpu_ready && n < 100);
    rd = cpu_rdata;
    cpu_req = 0;
    @(posedge clk); @(negedge clk);
  endtask

  // helper register access: one-cycle completion, no bus window (R11)
  task automatic hlp(input logic [3:0] a, input logic w, input logic [7:0] d, output logic [7:0] rd);
    int n; int t0;
    t0 = txn_cnt;
    cpu_access(a, w, d, rd, n);
    chk("R11", "helper latency", n, 1);
    chk("R11", "helper no bus", txn_cnt - t0, 0);
  endtask

  task automatic lcd_op(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] rd; int n; int t0; bit w; bit cmd; logic [7:0] exp_rd;
    w   = (a == 4'd0 || a == 4'd1);
    cmd = (a == 4'd0 || a == 4'd2);
    stat_val = 8'($urandom_range(0, 255)); if (stat_val == 8'h5A) stat_val = 8'hA5;
    data_val = 8'($urandom_range(0, 255)); if (data_val == 8'h5A) data_val = 8'h3C;
    exp_rd = cmd ? stat_val : data_val;
    t0 = txn_cnt;
    cpu_access(a, w, d, rd, n);
    chk("R2", "one window", txn_cnt - t0, 1);
    chk("R2", "cd level", int'(l_cd), int'(cmd));
    chk("R3", "setup", l_su, T_SU);
    chk("R3", "strobe width", l_pw, T_PW);
    chk("R3", "hold", l_hd, T_H);
    chk("R3", "cd stable", int'(l_cd_ok), 1);
    chk("R4", "ready latency", n, T_SU + T_PW + T_H + 1);
    if (w) begin
      chk("R2", "write strobe only", int'({l_wr, l_rd}), 2);
      chk("R2", "dout value", int'(l_dout), int'(d));
      chk("R6", "doe whole window", int'(l_doe_all), 1);
      chk("R6", "dout stable", int'(l_dout_ok), 1);
    end else begin
      chk("R2", "read strobe only", int'({l_wr, l_rd}), 1);
      chk("R6", "doe off on read", int'(l_doe_any), 0);
      chk("R5", "read data", int'(rd), int'(exp_rd));
    end
  endtask

  function automatic logic [15:0] txt_model(input logic [15:0] b, input int cols, input int r, input int c);
    int cc; cc = (cols > 40) ? 40 : cols;
    return 16'(int'(b) + r * cc + c);
  endfunction

  function automatic logic [15:0] gfx_model(input logic [15:0] b, input int bpl, input int r, input int c);
    int cb; cb = (bpl > 40) ? 40 : bpl;
    return 16'(int'(b) + r * cb + c / 6);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, lo, hi;
    int n, t0;
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "ce_n", int'(lcd_ce_n), 1);
    chk("R1", "wr_n/rd_n", int'({lcd_wr_n, lcd_rd_n}), 3);
    chk("R1", "doe", int'(lcd_doe), 0);
    chk("R1", "ready", int'(cpu_ready), 0);
    chk("R1", "rdata", int'(cpu_rdata), 0);

    // directed: each controller cycle type
    lcd_op(4'd0, 8'h3F);
    lcd_op(4'd1, 8'hC3);
    lcd_op(4'd2, 8'h00);
    lcd_op(4'd3, 8'h00);

    // R7 mismatched directions
    t0 = txn_cnt;
    cpu_access(4'd2, 1'b1, 8'h77, rd, n);
    chk("R7", "write to status latency", n, 1);
    cpu_access(4'd3, 1'b1, 8'h77, rd, n);
    chk("R7", "write to data-read latency", n, 1);
    cpu_access(4'd0, 1'b0, 8'h00, rd, n);
    chk("R7", "read of cmd rdata", int'(rd), 0);
    chk("R7", "read of cmd latency", n, 1);
    cpu_access(4'd1, 1'b0, 8'h00, rd, n);
    chk("R7", "read of data-wr rdata", int'(rd), 0);
    chk("R7", "no bus window", txn_cnt - t0, 0);

    // R9 clamping and R11 readback
    hlp(4'd6, 1, 8'd55, rd);  hlp(4'd6, 0, 0, rd);  chk("R9", "text cols clamp", int'(rd), 40);
    hlp(4'd6, 1, 8'd40, rd);  hlp(4'd6, 0, 0, rd);  chk("R9", "text cols at max", int'(rd), 40);
    hlp(4'd9, 1, 8'd200, rd); hlp(4'd9, 0, 0, rd);  chk("R9", "bpl clamp", int'(rd), 40);
    hlp(4'd9, 1, 8'd41, rd);  hlp(4'd9, 0, 0, rd);  chk("R9", "bpl just above", int'(rd), 40);
    hlp(4'd10, 1, 8'h9A, rd); hlp(4'd10, 0, 0, rd); chk("R11", "row readback", int'(rd), 8'h9A);
    hlp(4'd4, 1, 8'h12, rd);  hlp(4'd4, 0, 0, rd);  chk("R11", "base readback", int'(rd), 8'h12);
    hlp(4'd13, 1, 8'hFF, rd); hlp(4'd4, 0, 0, rd);  chk("R11", "write to 13 ignored", int'(rd), 8'h12);

    // R8 / R10 directed corner: first graphics byte of line 0 and text wrap past 16 bits
    hlp(4'd7, 1, 8'h00, rd); hlp(4'd8, 1, 8'h02, rd); hlp(4'd10, 1, 0, rd); hlp(4'd11, 1, 5, rd);
    hlp(4'd14, 0, 0, lo); hlp(4'd15, 0, 0, hi);
    chk("R10", "col 5 in byte 0", int'({hi, lo}), 16'h0200);
    hlp(4'd4, 1, 8'hF0, rd); hlp(4'd5, 1, 8'hFF, rd); hlp(4'd6, 1, 8'd40, rd);
    hlp(4'd10, 1, 8'd1, rd); hlp(4'd11, 1, 8'd39, rd);
    hlp(4'd12, 0, 0, lo); hlp(4'd13, 0, 0, hi);
    chk("R8", "text wrap", int'({hi, lo}), int'(txt_model(16'hFFF0, 40, 1, 39)));

    // random address arithmetic
    for (int i = 0; i < 12; i++) begin
      logic [15:0] tb_, gb_; int tc, bp, r, c;
      tb_ = 16'($urandom); gb_ = 16'($urandom);
      tc = $urandom_range(1, 60); bp = $urandom_range(1, 60);
      r = $urandom_range(0, 127); c = $urandom_range(0, 239);
      hlp(4'd4, 1, tb_[7:0], rd); hlp(4'd5, 1, tb_[15:8], rd); hlp(4'd6, 1, 8'(tc), rd);
      hlp(4'd7, 1, gb_[7:0], rd); hlp(4'd8, 1, gb_[15:8], rd); hlp(4'd9, 1, 8'(bp), rd);
      hlp(4'd10, 1, 8'(r), rd); hlp(4'd11, 1, 8'(c), rd);
      hlp(4'd12, 0, 0, lo); hlp(4'd13, 0, 0, hi);
      chk("R8", "text addr", int'({hi, lo}), int'(txt_model(tb_, tc, r, c)));
      hlp(4'd14, 0, 0, lo); hlp(4'd15, 0, 0, hi);
      chk("R10", "gfx addr", int'({hi, lo}), int'(gfx_model(gb_, bp, r, c)));
    end

    // random controller traffic
    for (int i = 0; i < 30; i++) begin
      lcd_op(4'($urandom_range(0, 3)), 8'($urandom_range(0, 255)));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule